// File: doc/BRIEF.md
# Adaptive Compression Decision Predictor

This block decides whether a cache level that can hold lines either packed or plain should pack the next line it allocates. Each cache reference is reported to it with the hit or miss outcome, whether the hit line is stored packed, its recency stack depth, and a flag from the tag logic. That flag says whether all lines down to that depth, at their packed sizes, would still fit in the set's segments. The block sorts each reference into one of five classes and keeps a signed benefit score, weighted in cycles.

References that packing made slower lower the score by the configured decompression latency. References that packing turned from a miss into a hit, and misses that packing would have prevented, raise it by the configured miss latency. The allocation logic reads a single decision bit. It packs the new line while the score is zero or above, and stores it plain while the score is negative. Typical configuration values are a 5-cycle decompression latency and a 400-cycle miss latency.

Top module: `adaptive_comp_predictor`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `benefit` is 0, `compress_en` is 1 and all five event outputs are 0.
- R2: A strobed hit with `ref_depth` at most 4 and `ref_compressed` low is unpenalized. After the next edge `ev_unpenalized` pulses and `benefit` is unchanged.
- R3: A strobed hit with `ref_depth` at most 4 and `ref_compressed` high is penalized. After the next edge `ev_penalized` pulses and `benefit` drops by `decomp_penalty`.
- R4: A strobed hit with `ref_depth` above 4 is an avoided miss, whatever `ref_compressed` is. After the next edge `ev_avoided_miss` pulses and `benefit` rises by `miss_penalty`.
- R5: A strobed miss with `ref_fits` high is avoidable. After the next edge `ev_avoidable_miss` pulses and `benefit` rises by `miss_penalty`.
- R6: A strobed miss with `ref_fits` low is unavoidable. After the next edge `ev_unavoidable_miss` pulses and `benefit` is unchanged.
- R7: `benefit` is 19-bit two's complement and saturates at +262143 and at -262144. It never wraps.
- R8: `compress_en` is 1 exactly when `benefit` is zero or positive.
- R9: Every strobe produces exactly one event pulse, one cycle long, in the cycle after the strobe. A cycle without a strobe produces no pulse and leaves `benefit` unchanged, whatever the other reference inputs are.
- R10: The penalty inputs are sampled only in the strobe cycle, so each reference is weighted by the penalties present with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference strobe, one per cache reference |
| ref_hit | input | 1 | Reference hit (1) or missed (0) |
| ref_compressed | input | 1 | Hit line is stored packed |
| ref_depth | input | 4 | Recency stack depth of the referenced tag, 1 = most recent |
| ref_fits | input | 1 | Packed sizes down to this depth fit in the set |
| decomp_penalty | input | 16 | Decompression latency in cycles |
| miss_penalty | input | 16 | Miss latency in cycles |
| compress_en | output | 1 | Pack the next allocated line |
| benefit | output | 19 | Signed benefit score |
| ev_unpenalized | output | 1 | Pulse: unpenalized hit |
| ev_penalized | output | 1 | Pulse: penalized hit |
| ev_avoided_miss | output | 1 | Pulse: hit that packing saved from missing |
| ev_avoidable_miss | output | 1 | Pulse: miss that packing would have saved |
| ev_unavoidable_miss | output | 1 | Pulse: miss packing could not save |

## Verification
The hardest states to reach are the two saturation rails. At typical latencies they take hundreds of references to reach. The stimulus drives the penalty inputs to their 16-bit maximum, so each rail is reached within a handful of references. It then keeps pushing against the rail and later crosses back through zero, which also exercises the decision bit at exactly zero. A long pseudo-random phase mixes classes, strobe gaps and changing penalties, and a cycle-level model checks every clock.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int CNT_W      = 19;
    localparam int PEN_W      = 16;
    localparam int DEPTH_W    = 4;
    localparam int NEAR_DEPTH = 4;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_HIT_PLAIN,
        CLS_HIT_SLOW,
        CLS_HIT_SAVED,
        CLS_MISS_SAVABLE,
        CLS_MISS_LOST
    } ref_class_e;

    typedef struct packed {
        logic               hit;
        logic               packed_line;
        logic [DEPTH_W-1:0] depth;
        logic               fits;
    } ref_req_t;

    typedef struct packed {
        logic unpen;
        logic pen;
        logic saved;
        logic savable;
        logic lost;
    } event_vec_t;

    function automatic ref_class_e classify(input ref_req_t r, input int near);
        ref_class_e c;
        if (r.hit) begin
            if (int'(r.depth) > near)  c = CLS_HIT_SAVED;
            else if (r.packed_line)    c = CLS_HIT_SLOW;
            else                       c = CLS_HIT_PLAIN;
        end else begin
            c = r.fits ? CLS_MISS_SAVABLE : CLS_MISS_LOST;
        end
        return c;
    endfunction

    function automatic event_vec_t class_to_events(input ref_class_e c);
        event_vec_t e;
        e         = '0;
        e.unpen   = (c == CLS_HIT_PLAIN);
        e.pen     = (c == CLS_HIT_SLOW);
        e.saved   = (c == CLS_HIT_SAVED);
        e.savable = (c == CLS_MISS_SAVABLE);
        e.lost    = (c == CLS_MISS_LOST);
        return e;
    endfunction

endpackage

// File: rtl/acp_classifier.sv
module acp_classifier
    import acp_pkg::*;
#(
    parameter int NEAR = NEAR_DEPTH
) (
    input  logic       strobe,
    input  ref_req_t   req,
    output ref_class_e cls,
    output logic       credit,
    output logic       debit
);
    always_comb begin
        cls = strobe ? classify(req, NEAR) : CLS_NONE;
        credit = (cls == CLS_HIT_SAVED) || (cls == CLS_MISS_SAVABLE);
        debit  = (cls == CLS_HIT_SLOW);
    end

    always_comb begin
        assert_no_dual_step_R9: assert (!(credit && debit));
    end
endmodule

// File: rtl/acp_sat_acc.sv
module acp_sat_acc #(
    parameter int CNT_W = acp_pkg::CNT_W,
    parameter int PEN_W = acp_pkg::PEN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    add_en,
    input  logic [PEN_W-1:0]        add_amt,
    input  logic                    sub_en,
    input  logic [PEN_W-1:0]        sub_amt,
    output logic signed [CNT_W-1:0] value
);
    localparam int EXT_W = ((PEN_W > CNT_W) ? PEN_W : CNT_W) + 2;
    localparam logic signed [EXT_W-1:0] MAX_EXT = EXT_W'((64'sd1 <<< (CNT_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] MIN_EXT = -MAX_EXT - EXT_W'(1);

    logic signed [EXT_W-1:0] cur_ext;
    logic signed [EXT_W-1:0] step;
    logic signed [EXT_W-1:0] raw;
    logic signed [EXT_W-1:0] clamped;

    always_comb begin
        cur_ext = EXT_W'(value);
        if (add_en)      step =  $signed({{(EXT_W-PEN_W){1'b0}}, add_amt});
        else if (sub_en) step = -$signed({{(EXT_W-PEN_W){1'b0}}, sub_amt});
        else             step = '0;
        raw = cur_ext + step;
        if (raw > MAX_EXT)      clamped = MAX_EXT;
        else if (raw < MIN_EXT) clamped = MIN_EXT;
        else                    clamped = raw;
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= clamped[CNT_W-1:0];
    end

    assert_credit_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
        add_en |=> value >= $past(value));
    assert_debit_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
        sub_en |=> value <= $past(value));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !sub_en) |=> $stable(value));
    assert_top_rail_R7: assert property (@(posedge clk) disable iff (rst)
        (add_en && EXT_W'(value) == MAX_EXT) |=> EXT_W'(value) == MAX_EXT);
    assert_bottom_rail_R7: assert property (@(posedge clk) disable iff (rst)
        (sub_en && EXT_W'(value) == MIN_EXT) |=> EXT_W'(value) == MIN_EXT);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> value == '0);
endmodule

// File: rtl/acp_event_reg.sv
module acp_event_reg
    import acp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ref_class_e cls,
    output event_vec_t ev
);
    always_ff @(posedge clk) begin
        if (rst) ev <= '0;
        else     ev <= class_to_events(cls);
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev));
endmodule

// File: rtl/adaptive_comp_predictor.sv
module adaptive_comp_predictor
    import acp_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PW   = PEN_W,
    parameter int NEAR = NEAR_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_valid,
    input  logic                 ref_hit,
    input  logic                 ref_compressed,
    input  logic [DEPTH_W-1:0]   ref_depth,
    input  logic                 ref_fits,
    input  logic [PW-1:0]        decomp_penalty,
    input  logic [PW-1:0]        miss_penalty,
    output logic                 compress_en,
    output logic signed [CW-1:0] benefit,
    output logic                 ev_unpenalized,
    output logic                 ev_penalized,
    output logic                 ev_avoided_miss,
    output logic                 ev_avoidable_miss,
    output logic                 ev_unavoidable_miss
);
    ref_req_t   req;
    ref_class_e cls;
    logic       credit;
    logic       debit;
    event_vec_t ev;

    always_comb begin
        req.hit         = ref_hit;
        req.packed_line = ref_compressed;
        req.depth       = ref_depth;
        req.fits        = ref_fits;
    end

    acp_classifier #(.NEAR(NEAR)) u_cls (
        .strobe (ref_valid),
        .req    (req),
        .cls    (cls),
        .credit (credit),
        .debit  (debit)
    );

    acp_sat_acc #(.CNT_W(CW), .PEN_W(PW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .add_en  (credit),
        .add_amt (miss_penalty),
        .sub_en  (debit),
        .sub_amt (decomp_penalty),
        .value   (benefit)
    );

    acp_event_reg u_evr (
        .clk (clk),
        .rst (rst),
        .cls (cls),
        .ev  (ev)
    );

    assign compress_en         = !benefit[CW-1];
    assign ev_unpenalized      = ev.unpen;
    assign ev_penalized        = ev.pen;
    assign ev_avoided_miss     = ev.saved;
    assign ev_avoidable_miss   = ev.savable;
    assign ev_unavoidable_miss = ev.lost;

    assert_strobe_gives_event_R9: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> $countones(ev) == 1);
    assert_quiet_no_event_R9: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |=> ev == '0);
    assert_neutral_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.lost || ev.unpen) |-> $stable(benefit));
    assert_penalized_drop_R3: assert property (@(posedge clk) disable iff (rst)
        ev.pen |-> benefit <= $past(benefit));
    assert_credit_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (ev.saved || ev.savable) |-> benefit >= $past(benefit));
endmodule

// File: tb/adaptive_comp_predictor_tb.sv
module adaptive_comp_predictor_tb;
    localparam int MAXV = 262143;
    localparam int MINV = -262144;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_valid = 1'b0;
    logic        ref_hit = 1'b0;
    logic        ref_compressed = 1'b0;
    logic [3:0]  ref_depth = 4'd1;
    logic        ref_fits = 1'b0;
    logic [15:0] decomp_penalty = 16'd5;
    logic [15:0] miss_penalty = 16'd400;
    logic        compress_en;
    logic signed [18:0] benefit;
    logic ev_unpenalized, ev_penalized, ev_avoided_miss, ev_avoidable_miss, ev_unavoidable_miss;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    logic [4:0] exp_ev = '0;
    string tag = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    adaptive_comp_predictor u_dut (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_hit(ref_hit),
        .ref_compressed(ref_compressed), .ref_depth(ref_depth), .ref_fits(ref_fits),
        .decomp_penalty(decomp_penalty), .miss_penalty(miss_penalty),
        .compress_en(compress_en), .benefit(benefit),
        .ev_unpenalized(ev_unpenalized), .ev_penalized(ev_penalized),
        .ev_avoided_miss(ev_avoided_miss), .ev_avoidable_miss(ev_avoidable_miss),
        .ev_unavoidable_miss(ev_unavoidable_miss)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [4:0] act_ev;
        act_ev = {ev_unpenalized, ev_penalized, ev_avoided_miss, ev_avoidable_miss, ev_unavoidable_miss};
        check(int'(benefit) == model, tag, "benefit", int'(benefit), model);
        check(act_ev == exp_ev, "R9", "events", int'(act_ev), int'(exp_ev));
        check(compress_en == (model >= 0), "R8", "compress_en", int'(compress_en), int'(model >= 0));
    endtask

    // Drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input bit v, input bit h, input bit c, input int d, input bit f,
                        input int dp, input int mp);
        int nxt;
        ref_valid = v; ref_hit = h; ref_compressed = c; ref_depth = 4'(d); ref_fits = f;
        decomp_penalty = 16'(dp); miss_penalty = 16'(mp);
        @(posedge clk);
        nxt = model;
        exp_ev = '0;
        tag = "R9";
        if (v) begin
            if (h && d > 4)  begin nxt = model + mp; exp_ev = 5'b00100; tag = "R4"; end
            else if (h && c) begin nxt = model - dp; exp_ev = 5'b01000; tag = "R3"; end
            else if (h)      begin exp_ev = 5'b10000; tag = "R2"; end
            else if (f)      begin nxt = model + mp; exp_ev = 5'b00010; tag = "R5"; end
            else             begin exp_ev = 5'b00001; tag = "R6"; end
        end
        if (nxt > MAXV) begin nxt = MAXV; tag = "R7"; end
        if (nxt < MINV) begin nxt = MINV; tag = "R7"; end
        model = nxt;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, with a strobe present that must be ignored
        ref_valid = 1'b1; ref_hit = 1'b0; ref_fits = 1'b1;
        @(negedge clk);
        tag = "R1"; exp_ev = '0; model = 0;
        check(int'(benefit) == 0, "R1", "benefit", int'(benefit), 0);
        check(compress_en == 1'b1, "R1", "compress_en", int'(compress_en), 1);
        compare_all();
        rst = 1'b0;
        ref_valid = 1'b0;
        @(negedge clk);
        compare_all();

        // one of each class at typical latencies (R2..R6)
        step(1, 1, 0, 2, 0, 5, 400);   // R2
        step(1, 1, 1, 4, 1, 5, 400);   // R3 boundary depth 4
        step(1, 1, 0, 5, 0, 5, 400);   // R4 depth 5, plain flag ignored
        step(1, 1, 1, 8, 0, 5, 400);   // R4
        step(1, 0, 0, 7, 1, 5, 400);   // R5
        step(1, 0, 1, 3, 0, 5, 400);   // R6
        // R9: no strobe, other inputs wiggling
        step(0, 1, 0, 9, 1, 77, 999);
        step(0, 0, 1, 1, 1, 77, 999);
        // R10: per-reference penalties
        step(1, 0, 0, 3, 1, 1, 123);
        step(1, 1, 1, 1, 0, 2222, 1);

        // R7: drive to the top rail and lean on it
        for (int i = 0; i < 8; i++) step(1, 0, 0, 6, 1, 5, 65535);
        check(int'(benefit) == MAXV, "R7", "top rail", int'(benefit), MAXV);
        step(1, 1, 1, 1, 0, 1, 5);
        step(1, 0, 0, 6, 1, 5, 65535);
        // fall through zero to the bottom rail (R8 at sign change)
        for (int i = 0; i < 12; i++) step(1, 1, 1, 2, 0, 65535, 400);
        check(int'(benefit) == MINV, "R7", "bottom rail", int'(benefit), MINV);
        check(compress_en == 1'b0, "R8", "negative decision", int'(compress_en), 0);
        step(1, 1, 1, 3, 1, 65535, 400);

        // R8: land exactly on zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; model = 0; exp_ev = '0;
        step(1, 1, 1, 1, 0, 300, 400);
        step(1, 0, 0, 1, 1, 5, 300);
        check(compress_en == 1'b1, "R8", "zero decision", int'(compress_en), 1);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 1023));
            step(r[0] | r[1], r[2], r[3], int'($urandom_range(0, 15)), r[4],
                 (r[9:8] == 2'b11) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 40)),
                 (r[7:6] == 2'b11) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 900)));
        end
        finish_run();
    end
endmodule